// File: doc/BRIEF.md
# Host Interrupt Request Flag Controller

This block owns the request flags that a microcontroller raises towards an external host across a low-pin-count host bus. It drives four kinds of request line: a keyboard-class line, a mouse-class line, a system-management line and a group of general-purpose lines. Each line is the OR of one or more one-bit enable flags held inside the block. Firmware sets a flag only through a guarded sequence. First it reads the flag while the flag is 0. Then it writes 1 to the flag. In the guarded case, it must also have written the paired data register first. The host drops a flag implicitly when it reads that paired data register.

A mode input selects between two regimes for every flag except the keyboard and mouse flags. With the mode low, these flags are guarded: setting them needs a prior data-register write, and a host read clears them. With the mode high, they behave directly: the read-0 then write-1 sequence alone sets them, and only a firmware write of 0 clears them. The keyboard and mouse flags are always guarded and ignore the mode. The block does not contain the data registers, the address decoding or the serial framing of the requests. It only receives strobes for accesses to those registers.

Top module: `hostreq_flags`

## Requirements
- R1: After a synchronous reset, every flag, every tracker and every request output is 0.
- R2: Flag index map on `cpuSel`: 0 keyboard (paired register 0), 1 mouse (register 0), 2 system-management via register 1, 3 system-management via register 2, 4 system-management via register 3, 5+g general line g via register 1, 9+g general line g via register 2 (g = 0..3). `kbdReq`=flag 0, `mouseReq`=flag 1, `smiReq`=OR of flags 2..4, `genReq[g]`=flag 5+g OR flag 9+g. Selects 13..15 address nothing.
- R3: A flag in guarded regime sets one cycle after a firmware write of 1 to it, provided two conditions hold. Its paired register was written since that register's last consumption. The flag was read as 0 since its last write.
- R4: A write of 1 to a flag that has not been read as 0 since its last write leaves the flag unchanged; any write to a flag, including a write of 0, disarms its read tracker.
- R5: In guarded regime, a write of 1 without a pending paired-register write leaves the flag at 0. Every guarded write of 1 that meets its guards consumes the pending write of its paired register, even one that loses to a host read.
- R6: A firmware write of 0 to a flag clears it on the next cycle in either regime.
- R7: In guarded regime, a host read strobe of a paired register clears all flags paired with it on the next cycle.
- R8: With `directMode`=1, flags 2..12 set on read-0 then write-1 with no register write; flags 0 and 1 still need one.
- R9: With `directMode`=1, host read strobes leave flags 2..12 unchanged.
- R10: When a host read of the paired register and a qualifying write of 1 fall in the same cycle, the flag ends cleared.
- R11: `cpuRdData` returns, in the same cycle and without a clock, the current value of the flag addressed by `cpuSel`. It returns 0 for unused selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| directMode | input | 1 | 1 selects the direct regime for flags 2..12 |
| cpuWr | input | 1 | Firmware write strobe to the flag selected by cpuSel |
| cpuRd | input | 1 | Firmware read strobe of the flag selected by cpuSel |
| cpuSel | input | 4 | Flag index |
| cpuWrData | input | 1 | Value written to the flag |
| cpuRdData | output | 1 | Current value of the selected flag |
| cpuDataWr | input | 4 | Firmware write strobes for data registers 0..3 |
| hostDataRd | input | 4 | Host read strobes for data registers 0..3 |
| kbdReq | output | 1 | Keyboard-class request |
| mouseReq | output | 1 | Mouse-class request |
| smiReq | output | 1 | System-management request |
| genReq | output | 4 | General-purpose requests |

## Verification
The full guarded sequence is run against sequences that each leave out one guard. One omits the read, one puts a write of 0 between read and write, one omits the register write, and one reuses a register write that was already consumed. Together they show that each guard is checked on its own. The same general line is raised through both of its paired registers, and then one register is read by the host. The line stays high until the second register is read as well, which confirms the OR of sources and the per-register clearing. The direct regime is tried with host reads that would clear in guarded mode, and with the keyboard flag, which must stay guarded. A cycle with a host read and a write of 1 together settles which of the two wins.

// File: rtl/hostreq_pkg.sv
package hostreq_pkg;
  localparam int GEN_LINES  = 4;
  localparam int NUM_REGS   = 4;
  localparam int NUM_BITS   = 5 + 2 * GEN_LINES;
  localparam int SEL_W      = $clog2(NUM_BITS);
  localparam int REG_W      = $clog2(NUM_REGS);

  localparam int KBD_BIT     = 0;
  localparam int MOUSE_BIT   = 1;
  localparam int SMI_FIRST   = 2;
  localparam int SMI_LAST    = 4;
  localparam int GEN_A_BASE  = 5;
  localparam int GEN_B_BASE  = GEN_A_BASE + GEN_LINES;

  // set/clear strobes from control to datapath; never both for one bit
  typedef struct packed {
    logic [NUM_BITS-1:0] setMask;
    logic [NUM_BITS-1:0] clrMask;
  } flagStrobes_t;

  // data register paired with each flag
  function automatic int pairOf(int b);
    if (b <= MOUSE_BIT)     return 0;
    else if (b == 2)        return 1;
    else if (b == 3)        return 2;
    else if (b == SMI_LAST) return 3;
    else if (b < GEN_B_BASE) return 1;
    else                    return 2;
  endfunction

  // flags that stay guarded regardless of the mode input
  function automatic bit alwaysGuarded(int b);
    return b <= MOUSE_BIT;
  endfunction
endpackage

// File: rtl/hostreq_ctrl.sv
module hostreq_ctrl
  import hostreq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                directMode,
  input  logic                cpuWr,
  input  logic                cpuRd,
  input  logic [SEL_W-1:0]    cpuSel,
  input  logic                cpuWrData,
  input  logic [NUM_REGS-1:0] cpuDataWr,
  input  logic [NUM_REGS-1:0] hostDataRd,
  input  logic [NUM_BITS-1:0] enBits,
  output flagStrobes_t        strobes
);
  logic [NUM_BITS-1:0] readArm;
  logic [NUM_REGS-1:0] regWritten;
  logic [NUM_BITS-1:0] consume;
  logic [NUM_REGS-1:0] regUsed;

  for (genvar b = 0; b < NUM_BITS; b++) begin : gBit
    localparam int  PAIR  = pairOf(b);
    localparam bit  FIXED = alwaysGuarded(b);
    logic selHit, wrHit, rdHit, guarded, guardOk, hostClr;

    assign selHit  = (cpuSel == SEL_W'(b));
    assign wrHit   = cpuWr && selHit;
    assign rdHit   = cpuRd && selHit;
    assign guarded = FIXED || !directMode;
    assign guardOk = wrHit && cpuWrData && readArm[b] &&
                     (!guarded || regWritten[PAIR]);
    assign hostClr = guarded && hostDataRd[PAIR];

    assign consume[b]         = guardOk && guarded;
    assign strobes.setMask[b] = guardOk && !hostClr;
    assign strobes.clrMask[b] = hostClr || (wrHit && !cpuWrData);

    always_ff @(posedge clk) begin
      if (rst)        readArm[b] <= 1'b0;
      else if (wrHit) readArm[b] <= 1'b0;
      else if (rdHit) readArm[b] <= !enBits[b];
    end
  end

  always_comb begin
    regUsed = '0;
    for (int b = 0; b < NUM_BITS; b++)
      if (consume[b]) regUsed[REG_W'(pairOf(b))] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) regWritten <= '0;
    else     regWritten <= cpuDataWr | (regWritten & ~regUsed);
  end
endmodule

// File: rtl/hostreq_datapath.sv
module hostreq_datapath
  import hostreq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  flagStrobes_t         strobes,
  input  logic [SEL_W-1:0]     cpuSel,
  output logic [NUM_BITS-1:0]  enBits,
  output logic                 cpuRdData,
  output logic                 kbdReq,
  output logic                 mouseReq,
  output logic                 smiReq,
  output logic [GEN_LINES-1:0] genReq
);
  localparam int PAD_W = 2 ** SEL_W;
  logic [PAD_W-1:0] padded;

  always_ff @(posedge clk) begin
    if (rst) enBits <= '0;
    else     enBits <= (enBits & ~strobes.clrMask) | strobes.setMask;
  end

  always_comb begin
    padded = '0;
    padded[NUM_BITS-1:0] = enBits;
  end
  assign cpuRdData = padded[cpuSel];

  assign kbdReq   = enBits[KBD_BIT];
  assign mouseReq = enBits[MOUSE_BIT];
  assign smiReq   = |enBits[SMI_LAST:SMI_FIRST];

  for (genvar g = 0; g < GEN_LINES; g++) begin : gLine
    assign genReq[g] = enBits[GEN_A_BASE + g] | enBits[GEN_B_BASE + g];
  end
endmodule

// File: rtl/hostreq_flags.sv
module hostreq_flags
  import hostreq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 directMode,
  input  logic                 cpuWr,
  input  logic                 cpuRd,
  input  logic [SEL_W-1:0]     cpuSel,
  input  logic                 cpuWrData,
  output logic                 cpuRdData,
  input  logic [NUM_REGS-1:0]  cpuDataWr,
  input  logic [NUM_REGS-1:0]  hostDataRd,
  output logic                 kbdReq,
  output logic                 mouseReq,
  output logic                 smiReq,
  output logic [GEN_LINES-1:0] genReq
);
  flagStrobes_t        strobes;
  logic [NUM_BITS-1:0] enBits;

  hostreq_ctrl uCtrl (
    .clk(clk), .rst(rst), .directMode(directMode), .cpuWr(cpuWr),
    .cpuRd(cpuRd), .cpuSel(cpuSel), .cpuWrData(cpuWrData),
    .cpuDataWr(cpuDataWr), .hostDataRd(hostDataRd), .enBits(enBits),
    .strobes(strobes)
  );

  hostreq_datapath uData (
    .clk(clk), .rst(rst), .strobes(strobes), .cpuSel(cpuSel),
    .enBits(enBits), .cpuRdData(cpuRdData), .kbdReq(kbdReq),
    .mouseReq(mouseReq), .smiReq(smiReq), .genReq(genReq)
  );
endmodule

// File: rtl/hostreq_flags_chk.sv
module hostreq_flags_chk
  import hostreq_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 directMode,
  input logic                 cpuWr,
  input logic [SEL_W-1:0]     cpuSel,
  input logic                 cpuWrData,
  input logic [NUM_REGS-1:0]  hostDataRd,
  input logic                 kbdReq,
  input logic                 mouseReq,
  input logic                 smiReq,
  input logic [GEN_LINES-1:0] genReq
);
  // R3
  kbd_rise_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(kbdReq) |-> $past(cpuWr && cpuWrData && cpuSel == SEL_W'(KBD_BIT)));

  // R3
  smi_rise_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(smiReq) |-> $past(cpuWr && cpuWrData));

  // R6
  kbd_write_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuWr && !cpuWrData && cpuSel == SEL_W'(KBD_BIT)) |=> !kbdReq);

  // R7
  host_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hostDataRd[0] |=> (!kbdReq && !mouseReq));

  // R9
  direct_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (directMode && !cpuWr) |=> ($stable(smiReq) && $stable(genReq)));
endmodule

bind hostreq_flags hostreq_flags_chk uChk (.*);

// File: tb/hostreq_flags_test.sv
`timescale 1ns/1ps
module hostreq_flags_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       directMode;
  logic       cpuWr, cpuRd, cpuWrData;
  logic [3:0] cpuSel;
  logic       cpuRdData;
  logic [3:0] cpuDataWr, hostDataRd;
  logic       kbdReq, mouseReq, smiReq;
  logic [3:0] genReq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hostreq_flags uut (
    .clk(clk), .rst(rst), .directMode(directMode), .cpuWr(cpuWr),
    .cpuRd(cpuRd), .cpuSel(cpuSel), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .cpuDataWr(cpuDataWr), .hostDataRd(hostDataRd),
    .kbdReq(kbdReq), .mouseReq(mouseReq), .smiReq(smiReq), .genReq(genReq)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle();
    cpuWr = 0; cpuRd = 0; cpuWrData = 0; cpuSel = 0;
    cpuDataWr = 0; hostDataRd = 0;
  endtask

  task automatic cpuWrite(int sel, bit d);
    @(negedge clk); cpuWr = 1; cpuSel = 4'(sel); cpuWrData = d;
    @(negedge clk); idle();
  endtask

  task automatic cpuRead(int sel, output bit v);
    @(negedge clk); cpuRd = 1; cpuSel = 4'(sel);
    #1 v = cpuRdData;
    @(negedge clk); idle();
  endtask

  task automatic regWrite(int r);
    @(negedge clk); cpuDataWr[r] = 1;
    @(negedge clk); idle();
  endtask

  task automatic hostRead(int r);
    @(negedge clk); hostDataRd[r] = 1;
    @(negedge clk); idle();
  endtask

  task automatic readThenSet(int sel);
    bit v;
    cpuRead(sel, v);
    cpuWrite(sel, 1);
  endtask

  task automatic t_reset();
    rst = 1; directMode = 0; idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 outputs", {kbdReq, mouseReq, smiReq, genReq}, 0);
  endtask

  task automatic t_keyboard();
    bit v;
    regWrite(0);
    readThenSet(0);
    check("R3 kbd set", kbdReq, 1);
    check("R2 mouse untouched", mouseReq, 0);
    cpuRead(0, v);
    check("R11 readback one", v, 1);
    hostRead(0);
    check("R7 host read clears kbd", kbdReq, 0);
  endtask

  task automatic t_unarmed();
    bit v;
    regWrite(0);
    cpuWrite(1, 1);
    check("R4 write without read", mouseReq, 0);
    cpuRead(1, v);
    check("R11 readback zero", v, 0);
    cpuWrite(1, 0);
    cpuWrite(1, 1);
    check("R4 write disarms", mouseReq, 0);
    readThenSet(1);
    check("R3 mouse set", mouseReq, 1);
    cpuWrite(1, 0);
    check("R6 write zero clears", mouseReq, 0);
  endtask

  task automatic t_consumed();
    regWrite(1);
    readThenSet(2);
    check("R3 smi via reg1", smiReq, 1);
    cpuWrite(2, 0);
    check("R6 smi clear", smiReq, 0);
    readThenSet(2);
    check("R5 consumed register write", smiReq, 0);
    readThenSet(5);
    check("R5 no register write", genReq[0], 0);
  endtask

  task automatic t_general_or();
    regWrite(2);
    readThenSet(10);
    check("R2 gen1 via reg2", genReq, 4'b0010);
    regWrite(1);
    readThenSet(6);
    hostRead(2);
    check("R2 gen1 held by second source", genReq[1], 1);
    hostRead(1);
    check("R7 gen1 cleared", genReq[1], 0);
  endtask

  task automatic t_twoway();
    regWrite(3);
    readThenSet(4);
    check("R3 smi via reg3", smiReq, 1);
    hostRead(3);
    check("R7 reg3 read clears smi", smiReq, 0);
  endtask

  task automatic t_direct();
    bit v;
    directMode = 1;
    readThenSet(3);
    check("R8 direct smi set", smiReq, 1);
    hostRead(2);
    check("R9 host read ignored", smiReq, 1);
    cpuWrite(3, 0);
    check("R6 direct clear", smiReq, 0);
    readThenSet(12);
    hostRead(2);
    check("R9 gen3 kept", genReq[3], 1);
    cpuWrite(12, 0);
    readThenSet(0);
    check("R8 kbd still guarded", kbdReq, 0);
    cpuRead(14, v);
    check("R11 unused select", v, 0);
    directMode = 0;
  endtask

  task automatic t_race();
    bit v;
    regWrite(0);
    cpuRead(0, v);
    @(negedge clk); cpuWr = 1; cpuSel = 0; cpuWrData = 1; hostDataRd[0] = 1;
    @(negedge clk); idle();
    check("R10 host read wins", kbdReq, 0);
    readThenSet(0);
    check("R5 losing write consumed", kbdReq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_keyboard();
    t_unarmed();
    t_consumed();
    t_general_or();
    t_twoway();
    t_direct();
    t_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule